// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block keeps a direct-mapped array of two-bit saturating counters and uses it to guess whether a conditional branch will be taken. The fetch stage presents an instruction address. In the same cycle the block returns the counter for that address and a taken or not-taken guess. Each accepted guess is remembered in a small in-order pending list, together with the table index it used, and receives a short tag. When the branch resolves later, the execute stage returns the tag and the real outcome. The block then steps the counter recorded for the oldest pending guess.

A bulk clear wipes the history. It walks through the whole array, one entry per cycle, and writes the weakly-not-taken state. Reset uses the same walk but writes the strongly-not-taken state, so the two starting points are different. While a walk is running, lookups report weakly not taken and resolved outcomes are dropped. The pending list holds at most three unresolved guesses. When it is full, a new guess is refused with a stall.

Top module: `bht_predictor`

## Requirements
- R1: The counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. When no walk is running, `pred_ctr` is the counter of entry `pred_pc[12:2]` in the same cycle, and `pred_taken` is its bit 1. Address bits outside [12:2] do not select the entry.
- R2: An accepted resolution moves the recorded counter one step toward 11 on a taken outcome and one step toward 00 otherwise. It stays at 11 or 00 when already there.
- R3: After reset is released, `clr_busy` stays high for 2048 cycles, and then every entry holds 00.
- R4: A `clr_req` sampled while idle raises `clr_busy` from the next cycle for exactly 2048 cycles, and then every entry holds 01. While `clr_busy` is high, `pred_ctr` is 01 and `pred_taken` is 0.
- R5: A `clr_req` sampled while `clr_busy` is high has no effect on the walk length.
- R6: A resolution accepted while `clr_busy` is high removes its pending entry but changes no counter.
- R7: `pred_stall` is high exactly when three guesses are pending. A `pred_req` made while it is high is not recorded.
- R8: The n-th accepted guess since reset (counting from 0) gets `pred_tag` = n mod 4. A resolution is accepted only if the list is not empty and `upd_tag` equals the tag of the oldest pending guess. Any other resolution is ignored.
- R9: A resolution updates the entry indexed by the oldest pending guess's address, even if other guesses were made after it.
- R10: When a lookup and an update hit the same entry in the same cycle, the lookup returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_req | input | 1 | A branch asks for a guess this cycle |
| pred_pc | input | 32 | Instruction address of the branch |
| pred_taken | output | 1 | Guessed direction |
| pred_ctr | output | 2 | Counter value behind the guess |
| pred_tag | output | 2 | Tag given to a guess accepted this cycle |
| pred_stall | output | 1 | Pending list full; the guess is refused |
| upd_valid | input | 1 | A resolved outcome is presented |
| upd_tag | input | 2 | Tag of the resolving branch |
| upd_taken | input | 1 | Real outcome: 1 taken |
| clr_req | input | 1 | Request a bulk clear to weakly not taken |
| clr_busy | output | 1 | A reset or clear walk is in progress |

## Verification
The counters can only be seen through lookups, so a wrongly stepped or unsaturated counter appears at `pred_ctr` the first time its entry is looked up again. The bench looks up trained entries right after each update. A wrong index recorded in the pending list shows up as a change at the wrong entry, which the aliasing and interleaved phases expose. A bad walk counter changes the length of `clr_busy`, and a wrong fill value is seen on the first lookup after the walk. Both are caught within one cycle of the walk ending, because outputs are compared against the model on every cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // one saturating step toward the observed outcome
  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_ST) ? c : c + 2'b01;
    else       r = (c == CTR_SNT) ? c : c - 2'b01;
    return r;
  endfunction

  // true when n is one step or zero steps away from o
  function automatic logic ctr_near(ctr_t o, ctr_t n);
    return (n == o) || (n == o + 2'b01) || (n == o - 2'b01);
  endfunction
endpackage

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int IDX_W = 11,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] rd2_idx,
  output ctr_t             rd2_ctr,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  ctr_t mem [DEPTH];

  assign rd_ctr  = mem[rd_idx];
  assign rd2_ctr = mem[rd2_idx];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_ctr;
  end
endmodule

// File: rtl/bht_sweep.sv
module bht_sweep
  import bht_pkg::*;
#(
  parameter int IDX_W = 11,
  localparam logic [IDX_W-1:0] LAST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output ctr_t             fill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
      fill <= CTR_SNT;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end else if (clr_req) begin
      busy <= 1'b1;
      idx  <= '0;
      fill <= CTR_WNT;
    end
  end

  assert_walk_ends_at_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(idx) == LAST);
  assert_walk_starts_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clr_req) && (idx == '0));
endmodule

// File: rtl/bht_pend_queue.sv
module bht_pend_queue #(
  parameter int DEPTH = 3,
  parameter int IDX_W = 11,
  parameter int TAG_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [IDX_W-1:0] push_idx,
  output logic [TAG_W-1:0] push_tag,
  output logic             full,
  output logic             push_ok,
  input  logic             pop_req,
  input  logic [TAG_W-1:0] pop_tag,
  output logic             pop_ok,
  output logic [IDX_W-1:0] head_idx
);
  logic [IDX_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] rd_tag;
  logic [CNT_W-1:0] wsel;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign push_ok  = push_req && !full;
  assign pop_ok   = pop_req && (cnt != '0) && (pop_tag == rd_tag);
  assign head_idx = slot[0];
  assign wsel     = pop_ok ? cnt - 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      push_tag <= '0;
      rd_tag   <= '0;
    end else begin
      cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push_ok) push_tag <= push_tag + 1'b1;
      if (pop_ok)  rd_tag   <= rd_tag + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
    end
    if (push_ok) slot[wsel] <= push_idx;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> cnt == $past(cnt) + 1'b1);
  assert_tags_distance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_tag - rd_tag) == TAG_W'(cnt));
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 11,
  parameter int IDX_LO   = 2,
  parameter int MAX_PEND = 3,
  localparam int TAG_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_req,
  input  logic [ADDR_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic [1:0]        pred_ctr,
  output logic [TAG_W-1:0]  pred_tag,
  output logic              pred_stall,
  input  logic              upd_valid,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              upd_taken,
  input  logic              clr_req,
  output logic              clr_busy
);
  logic [IDX_W-1:0] look_idx, head_idx, sw_idx, wr_idx;
  ctr_t             look_ctr, upd_old, upd_new, sw_fill, wr_ctr;
  logic             push_ok, pop_ok, upd_we, tbl_we;

  assign look_idx = pred_pc[IDX_LO +: IDX_W];

  bht_sweep #(.IDX_W(IDX_W)) sweep_i (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .busy(clr_busy), .idx(sw_idx), .fill(sw_fill)
  );

  bht_pend_queue #(.DEPTH(MAX_PEND), .IDX_W(IDX_W), .TAG_W(TAG_W)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .push_req(pred_req), .push_idx(look_idx), .push_tag(pred_tag),
    .full(pred_stall), .push_ok(push_ok),
    .pop_req(upd_valid), .pop_tag(upd_tag), .pop_ok(pop_ok),
    .head_idx(head_idx)
  );

  assign upd_new = ctr_step(upd_old, upd_taken);
  assign upd_we  = pop_ok && !clr_busy;
  assign tbl_we  = clr_busy || upd_we;
  assign wr_idx  = clr_busy ? sw_idx  : head_idx;
  assign wr_ctr  = clr_busy ? sw_fill : upd_new;

  bht_table #(.IDX_W(IDX_W)) table_i (
    .clk(clk),
    .rd_idx(look_idx), .rd_ctr(look_ctr),
    .rd2_idx(head_idx), .rd2_ctr(upd_old),
    .we(tbl_we), .wr_idx(wr_idx), .wr_ctr(wr_ctr)
  );

  assign pred_ctr   = clr_busy ? CTR_WNT : look_ctr;
  assign pred_taken = pred_ctr[1];

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> ctr_near(upd_old, wr_ctr));
  assert_refused_not_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && pred_stall) |=> pred_stall || $past(pop_ok));
endmodule

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_req = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_ctr;
  logic [1:0]  pred_tag;
  logic        pred_stall;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_tag = '0;
  logic        upd_taken = 1'b0;
  logic        clr_req = 1'b0;
  logic        clr_busy;

  int checks = 0;
  int fails  = 0;
  string phase = "R3";

  // behavioural model
  int m_tbl [2048];
  int m_q [$];
  int m_alloc = 0, m_retire = 0;
  bit m_busy = 1'b1;
  int m_sidx = 0, m_fill = 0;

  always #2 clk = ~clk;

  bht_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_ctr(pred_ctr), .pred_tag(pred_tag),
    .pred_stall(pred_stall), .upd_valid(upd_valid), .upd_tag(upd_tag),
    .upd_taken(upd_taken), .clr_req(clr_req), .clr_busy(clr_busy)
  );

  function automatic int sat_move(int v, bit t);
    if (t) return (v >= 3) ? 3 : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  // one cycle: inputs already driven; compare, advance model, cross an edge
  task automatic step();
    int e_ctr;
    bit pop, push;
    #1;
    e_ctr = m_busy ? 1 : m_tbl[(pred_pc >> 2) % 2048];
    cmp("R1 ctr", pred_ctr, e_ctr);
    cmp("R1 taken", pred_taken, e_ctr / 2);
    cmp("R7 stall", pred_stall, m_q.size() == 3);
    cmp("R8 tag", pred_tag, m_alloc % 4);
    cmp("R4 busy", clr_busy, m_busy);
    pop  = upd_valid && m_q.size() > 0 && upd_tag == 2'(m_retire % 4);
    push = pred_req && m_q.size() < 3;
    if (pop) begin
      if (!m_busy) m_tbl[m_q[0]] = sat_move(m_tbl[m_q[0]], upd_taken);
      void'(m_q.pop_front());
      m_retire++;
    end
    if (push) begin
      m_q.push_back((pred_pc >> 2) % 2048);
      m_alloc++;
    end
    if (m_busy) begin
      m_tbl[m_sidx] = m_fill;
      if (m_sidx == 2047) m_busy = 0; else m_sidx++;
    end else if (clr_req) begin
      m_busy = 1; m_sidx = 0; m_fill = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    pred_req = 0; upd_valid = 0; clr_req = 0;
  endtask

  task automatic predict(int pc);
    idle(); pred_req = 1; pred_pc = pc; step();
  endtask

  task automatic resolve(bit t, int tag, int look_pc);
    idle(); upd_valid = 1; upd_taken = t; upd_tag = tag; pred_pc = look_pc; step();
  endtask

  task automatic look(int pc);
    idle(); pred_pc = pc; step();
  endtask

  task automatic wait_walk();
    while (m_busy) begin idle(); step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3: reset walk lasts 2048 cycles and leaves 00 everywhere
    phase = "R3";
    wait_walk();
    for (int i = 0; i < 40; i++) look(i * 204 + 3);

    // R2 / R1: train one entry up to saturation and back down
    phase = "R2";
    for (int k = 0; k < 5; k++) begin
      predict(32'h100); resolve(1, m_retire % 4, 32'h100);
    end
    for (int k = 0; k < 5; k++) begin
      predict(32'h100); resolve(0, m_retire % 4, 32'h100);
    end
    // R1: aliasing of address bits above 12 and below 2
    phase = "R1";
    predict(32'h0000_0204); resolve(1, m_retire % 4, 32'h0000_0204);
    predict(32'h0000_0204); resolve(1, m_retire % 4, 32'h0000_0204);
    look(32'hFFFF_E207); look(32'h0000_0208);

    // R7: three pending then refused fourth
    phase = "R7";
    predict(32'h400); predict(32'h800); predict(32'hC00);
    predict(32'h1000); predict(32'h1000);
    // R8: wrong tag ignored, then correct order; R9: oldest index used
    phase = "R8";
    resolve(1, (m_retire + 1) % 4, 32'h400);
    phase = "R9";
    resolve(1, m_retire % 4, 32'h400);
    look(32'h800); look(32'hC00);
    resolve(0, m_retire % 4, 32'h800);
    resolve(1, m_retire % 4, 32'hC00);
    resolve(1, m_retire % 4, 32'hC00);
    look(32'h1000);

    // R10: lookup and update of the same entry in one cycle
    phase = "R10";
    predict(32'h2000);
    idle(); upd_valid = 1; upd_taken = 1; upd_tag = m_retire % 4;
    pred_req = 1; pred_pc = 32'h2000; step();
    resolve(1, m_retire % 4, 32'h2000);

    // R4: clear walk, R6: update during walk, R5: clear during walk
    phase = "R4";
    predict(32'h3000);
    idle(); clr_req = 1; step();
    phase = "R6";
    resolve(1, m_retire % 4, 32'h3000);
    phase = "R5";
    for (int k = 0; k < 100; k++) begin idle(); step(); end
    idle(); clr_req = 1; step();
    phase = "R4";
    wait_walk();
    for (int i = 0; i < 40; i++) look(i * 204 + 1);
    look(32'h3000); look(32'h100);

    // mixed traffic against the model
    phase = "R8";
    for (int n = 0; n < 3000; n++) begin
      idle();
      pred_req = $urandom_range(0, 1);
      pred_pc  = $urandom_range(0, 15) * 4 + ($urandom_range(0, 1) << 13);
      upd_valid = $urandom_range(0, 2) != 0;
      upd_taken = $urandom_range(0, 3) != 0;
      upd_tag   = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'(m_retire % 4);
      clr_req   = ($urandom_range(0, 999) == 0);
      step();
    end
    wait_walk();
    for (int i = 0; i < 16; i++) look(i * 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule